// File: doc/BRIEF.md
# FP64 Special-Value Fixup Unit

This block repairs a single double-precision result whose input was a special value. It first optionally flushes a denormal source to +0.0, then sorts the (possibly flushed) value into one of eight classes. Each class owns a 4-bit slot in a 32-bit table operand, and the code held in that slot decides what the output is. The output can be the prior destination value, the source itself, a quieted copy of the source, or one of a set of fixed constants such as infinities, signed zeros, +/-1, 0.5, 90.0, pi/2, the largest finite magnitudes and the default NaN.

Alongside the value, the unit raises zero-divide and invalid flag pulses. An 8-bit report mask enables them, with separate enables for each class. A per-lane write-enable with merge or zeroing behaviour suppresses both the fixup and the flags. A typical use places it after an iterative approximation sequence, such as a Newton-Raphson reciprocal. There it forces the exact answer for inputs like zero, infinity or NaN that the iteration handles badly.

A parameter selects a zero- or one-cycle registered output. All results and flags share the same latency.

Top module: `fpfix_unit`

## Requirements
- R1: The working value is classified into these class codes: quiet NaN=0, signaling NaN=1, zero of either sign=2, exactly +1.0 (0x3FF0000000000000)=3, -infinity=4, +infinity=5, any other negative=6, any other positive=7. -1.0 is class 6. A NaN has an all-ones exponent and a nonzero fraction, and it is quiet when fraction bit 51 is 1.
- R2: When the flush control is 1 and source bits [62:52] are all zero, the working value is +0.0 (all 64 bits zero) regardless of sign, and it is classified as zero.
- R3: When the flush control is 0, a denormal source is its own working value and is classified as 6 or 7 by its sign bit.
- R4: The response code for class j is table bits [4j+3:4j].
- R5: Code 0 outputs the prior destination value. Code 1 outputs the working value. Code 2 outputs the working value with bit 51 set, keeping the sign and other bits. Code 3 outputs 0xFFF8000000000000.
- R6: Code 4 outputs -infinity (0xFFF0000000000000). Code 5 outputs +infinity (0x7FF0000000000000). Code 6 outputs infinity with the working value's sign. Code 7 outputs -0 (0x8000000000000000). Code 8 outputs +0.
- R7: Codes 9 to 15 output these values: -1.0 (0xBFF0000000000000), +1.0, 0.5 (0x3FE0000000000000), 90.0 (0x4056800000000000), pi/2 (0x3FF921FB54442D18), 0x7FEFFFFFFFFFFFFF, 0xFFEFFFFFFFFFFFFF.
- R8: Class 2 raises zero-divide if mask bit 0 is set and invalid if mask bit 1 is set. Class 3 raises zero-divide if mask bit 2 is set and invalid if mask bit 3 is set. Both flags may be high together.
- R9: Invalid is raised for class 1 under mask bit 4, for class 4 under bit 5, for class 6 under bit 6 and for class 5 under bit 7. Classes 0 and 7 raise no flag, and no other mask bit raises zero-divide.
- R10: With the write-enable at 0, the result is the prior destination value when the zeroing control is 0, and all zeros when it is 1. Both flags stay 0.
- R11: With one pipeline stage (the default), result and flags appear one clock after their inputs and hold between edges. During reset the result and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Source value to fix up |
| tbl_i | input | 32 | Per-class response table, 4 bits per class |
| prior_i | input | 64 | Prior destination value |
| rmask_i | input | 8 | Flag report enables |
| daz_i | input | 1 | Flush denormal source to +0.0 |
| wen_i | input | 1 | Write-enable for the lane |
| zero_mode_i | input | 1 | 1: disabled lane outputs zero; 0: disabled lane keeps prior |
| result_o | output | 64 | Fixed-up result |
| zdiv_o | output | 1 | Zero-divide flag pulse |
| inval_o | output | 1 | Invalid flag pulse |

## Verification
In the default configuration, the result and both flags are due at the first rising edge after the inputs are applied. The bench drives each vector on a falling edge and samples one time unit after the next rising edge. Just before it drives a new vector, it also confirms that the outputs still hold the previous vector's answer, which pins the latency to exactly one cycle. The checker follows the same rule: it keeps a one-cycle copy of the inputs and compares the outputs against that copy, and it stays silent until that copy holds a post-reset vector.

// File: rtl/fpfix_pkg.sv
`timescale 1ns/1ps
package fpfix_pkg;
   localparam int FIX_TOKENS = 8;
   localparam int FIX_CODE_W = 4;

   typedef enum logic [2:0] {
      TK_QNAN = 3'd0,
      TK_SNAN = 3'd1,
      TK_ZERO = 3'd2,
      TK_PONE = 3'd3,
      TK_NINF = 3'd4,
      TK_PINF = 3'd5,
      TK_NEG  = 3'd6,
      TK_POS  = 3'd7
   } fix_token_e;

   // constants that cannot be derived from field widths alone
   localparam logic [63:0] FP64_NINETY  = 64'h4056_8000_0000_0000;
   localparam logic [63:0] FP64_HALF_PI = 64'h3FF9_21FB_5444_2D18;
endpackage

// File: rtl/fpfix_classify.sv
`timescale 1ns/1ps
module fpfix_classify
   import fpfix_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int DATA_W = 1 + EXP_W + MAN_W
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic              daz_i,
   output logic [DATA_W-1:0] work_o,
   output fix_token_e        token_o
);
   localparam logic [DATA_W-1:0] PLUS_ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

   logic [EXP_W-1:0] s_exp, w_exp;
   logic [MAN_W-1:0] w_man;
   logic             w_sgn;

   assign s_exp  = src_i[DATA_W-2 -: EXP_W];
   assign work_o = (daz_i && s_exp == '0) ? '0 : src_i;

   assign w_sgn = work_o[DATA_W-1];
   assign w_exp = work_o[DATA_W-2 -: EXP_W];
   assign w_man = work_o[MAN_W-1:0];

   always_comb begin
      if (&w_exp) begin
         if (w_man != '0) token_o = w_man[MAN_W-1] ? TK_QNAN : TK_SNAN;
         else             token_o = w_sgn ? TK_NINF : TK_PINF;
      end else if (w_exp == '0 && w_man == '0) begin
         token_o = TK_ZERO;
      end else if (work_o == PLUS_ONE) begin
         token_o = TK_PONE;
      end else begin
         token_o = w_sgn ? TK_NEG : TK_POS;
      end
   end
endmodule

// File: rtl/fpfix_respond.sv
`timescale 1ns/1ps
module fpfix_respond
   import fpfix_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int DATA_W = 1 + EXP_W + MAN_W,
   localparam int TBL_W  = FIX_TOKENS * FIX_CODE_W
) (
   input  logic [DATA_W-1:0] work_i,
   input  fix_token_e        token_i,
   input  logic [TBL_W-1:0]  tbl_i,
   input  logic [DATA_W-1:0] prior_i,
   output logic [DATA_W-1:0] fixed_o
);
   localparam int MAG_W = DATA_W - 1;
   localparam int QBIT  = MAN_W - 1;
   localparam logic [MAG_W-1:0] MAG_ONE  = {1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
   localparam logic [MAG_W-1:0] MAG_HALF = {1'b0, {(EXP_W-2){1'b1}}, 1'b0, {MAN_W{1'b0}}};
   localparam logic [MAG_W-1:0] MAG_INF  = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
   localparam logic [MAG_W-1:0] MAG_MAX  = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
   localparam logic [DATA_W-1:0] DFLT_NAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic [FIX_CODE_W-1:0] code;
   assign code = tbl_i[int'(token_i) * FIX_CODE_W +: FIX_CODE_W];

   always_comb begin
      unique case (code)
         4'd0:  fixed_o = prior_i;
         4'd1:  fixed_o = work_i;
         4'd2:  fixed_o = work_i | (DATA_W'(1) << QBIT);
         4'd3:  fixed_o = DFLT_NAN;
         4'd4:  fixed_o = {1'b1, MAG_INF};
         4'd5:  fixed_o = {1'b0, MAG_INF};
         4'd6:  fixed_o = {work_i[DATA_W-1], MAG_INF};
         4'd7:  fixed_o = {1'b1, {MAG_W{1'b0}}};
         4'd8:  fixed_o = '0;
         4'd9:  fixed_o = {1'b1, MAG_ONE};
         4'd10: fixed_o = {1'b0, MAG_ONE};
         4'd11: fixed_o = {1'b0, MAG_HALF};
         4'd12: fixed_o = FP64_NINETY;
         4'd13: fixed_o = FP64_HALF_PI;
         4'd14: fixed_o = {1'b0, MAG_MAX};
         default: fixed_o = {1'b1, MAG_MAX};
      endcase
   end
endmodule

// File: rtl/fpfix_flags.sv
`timescale 1ns/1ps
module fpfix_flags
   import fpfix_pkg::*;
(
   input  fix_token_e  token_i,
   input  logic [7:0]  rmask_i,
   output logic        zdiv_o,
   output logic        inval_o
);
   always_comb begin
      zdiv_o  = 1'b0;
      inval_o = 1'b0;
      unique case (token_i)
         TK_ZERO: begin zdiv_o = rmask_i[0]; inval_o = rmask_i[1]; end
         TK_PONE: begin zdiv_o = rmask_i[2]; inval_o = rmask_i[3]; end
         TK_SNAN: inval_o = rmask_i[4];
         TK_NINF: inval_o = rmask_i[5];
         TK_NEG:  inval_o = rmask_i[6];
         TK_PINF: inval_o = rmask_i[7];
         default: ;
      endcase
   end
endmodule

// File: rtl/fpfix_unit.sv
`timescale 1ns/1ps
module fpfix_unit
   import fpfix_pkg::*;
#(
   parameter int EXP_W       = 11,
   parameter int MAN_W       = 52,
   parameter int PIPE_STAGES = 1,
   localparam int DATA_W = 1 + EXP_W + MAN_W,
   localparam int TBL_W  = FIX_TOKENS * FIX_CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [TBL_W-1:0]  tbl_i,
   input  logic [DATA_W-1:0] prior_i,
   input  logic [7:0]        rmask_i,
   input  logic              daz_i,
   input  logic              wen_i,
   input  logic              zero_mode_i,
   output logic [DATA_W-1:0] result_o,
   output logic              zdiv_o,
   output logic              inval_o
);
   generate
      if (EXP_W != 11 || MAN_W != 52) begin : g_bad_fmt
         $error("fpfix_unit: only the binary64 layout is supported");
      end
      if (PIPE_STAGES < 0 || PIPE_STAGES > 1) begin : g_bad_pipe
         $error("fpfix_unit: PIPE_STAGES must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] work, fixed, nxt_res;
   fix_token_e        token;
   logic              zd_raw, iv_raw, nxt_zd, nxt_iv;

   fpfix_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_class (
      .src_i   (src_i),
      .daz_i   (daz_i),
      .work_o  (work),
      .token_o (token)
   );

   fpfix_respond #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_resp (
      .work_i  (work),
      .token_i (token),
      .tbl_i   (tbl_i),
      .prior_i (prior_i),
      .fixed_o (fixed)
   );

   fpfix_flags i_flags (
      .token_i (token),
      .rmask_i (rmask_i),
      .zdiv_o  (zd_raw),
      .inval_o (iv_raw)
   );

   always_comb begin
      if (wen_i)            nxt_res = fixed;
      else if (zero_mode_i) nxt_res = '0;
      else                  nxt_res = prior_i;
      nxt_zd = wen_i & zd_raw;
      nxt_iv = wen_i & iv_raw;
   end

   generate
      if (PIPE_STAGES == 1) begin : g_reg
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               result_o <= '0;
               zdiv_o   <= 1'b0;
               inval_o  <= 1'b0;
            end else begin
               result_o <= nxt_res;
               zdiv_o   <= nxt_zd;
               inval_o  <= nxt_iv;
            end
         end
      end else begin : g_comb
         assign result_o = nxt_res;
         assign zdiv_o   = nxt_zd;
         assign inval_o  = nxt_iv;
      end
   endgenerate
endmodule

// File: rtl/fpfix_unit_chk.sv
`timescale 1ns/1ps
module fpfix_unit_chk #(
   parameter int EXP_W       = 11,
   parameter int MAN_W       = 52,
   parameter int PIPE_STAGES = 1,
   localparam int DATA_W = 1 + EXP_W + MAN_W,
   localparam int TBL_W  = 32
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [DATA_W-1:0] src_i,
   input logic [TBL_W-1:0]  tbl_i,
   input logic [DATA_W-1:0] prior_i,
   input logic [7:0]        rmask_i,
   input logic              daz_i,
   input logic              wen_i,
   input logic              zero_mode_i,
   input logic [DATA_W-1:0] result_o,
   input logic              zdiv_o,
   input logic              inval_o
);
   logic [DATA_W-1:0] src_d, prior_d;
   logic [TBL_W-1:0]  tbl_d;
   logic [7:0]        rmask_d;
   logic              daz_d, wen_d, zm_d, primed;

   generate
      if (PIPE_STAGES == 1) begin : g_dly
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               primed <= 1'b0;
               src_d <= '0; prior_d <= '0; tbl_d <= '0; rmask_d <= '0;
               daz_d <= 1'b0; wen_d <= 1'b0; zm_d <= 1'b0;
            end else begin
               primed <= 1'b1;
               src_d <= src_i; prior_d <= prior_i; tbl_d <= tbl_i; rmask_d <= rmask_i;
               daz_d <= daz_i; wen_d <= wen_i; zm_d <= zero_mode_i;
            end
         end
      end else begin : g_now
         assign primed = 1'b1;
         assign src_d = src_i; assign prior_d = prior_i; assign tbl_d = tbl_i;
         assign rmask_d = rmask_i; assign daz_d = daz_i; assign wen_d = wen_i;
         assign zm_d = zero_mode_i;
      end
   endgenerate

   logic [EXP_W-1:0] d_exp;
   logic [MAN_W-1:0] d_man;
   assign d_exp = src_d[DATA_W-2 -: EXP_W];
   assign d_man = src_d[MAN_W-1:0];

   assert_masked_silent_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && !wen_d) |-> (!zdiv_o && !inval_o));

   assert_zeroing_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && !wen_d && zm_d) |-> (result_o == '0));

   assert_merging_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && !wen_d && !zm_d) |-> (result_o == prior_d));

   assert_keep_prior_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && wen_d && tbl_d == '0) |-> (result_o == prior_d));

   assert_flush_pass_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && wen_d && daz_d && d_exp == '0 && tbl_d == {8{4'h1}}) |-> (result_o == '0));

   assert_qnan_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && (&d_exp) && d_man[MAN_W-1]) |-> (!zdiv_o && !inval_o));

   assert_zdiv_enable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (primed && zdiv_o) |-> (wen_d && (rmask_d[0] || rmask_d[2])));
endmodule

bind fpfix_unit fpfix_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PIPE_STAGES(PIPE_STAGES)) i_chk (
   .clk_i(clk_i), .rst_i(rst_i), .src_i(src_i), .tbl_i(tbl_i), .prior_i(prior_i),
   .rmask_i(rmask_i), .daz_i(daz_i), .wen_i(wen_i), .zero_mode_i(zero_mode_i),
   .result_o(result_o), .zdiv_o(zdiv_o), .inval_o(inval_o)
);

// File: tb/test_fpfix_unit.sv
`timescale 1ns/1ps
module test_fpfix_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] src = '0, prior = '0;
   logic [31:0] tbl = '0;
   logic [7:0]  rmask = '0;
   logic        daz = 1'b0, wen = 1'b0, zm = 1'b0;
   logic [63:0] result;
   logic        zdiv, inval;

   int n_cmp = 0;
   int n_bad = 0;
   logic [63:0] prev_res = '0;
   logic        prev_zd = 1'b0, prev_iv = 1'b0;
   logic [31:0] rng = 32'h1234_5678;

   always #4 clk = ~clk;

   fpfix_unit i_fpfix_unit (
      .clk_i(clk), .rst_i(rst), .src_i(src), .tbl_i(tbl), .prior_i(prior),
      .rmask_i(rmask), .daz_i(daz), .wen_i(wen), .zero_mode_i(zm),
      .result_o(result), .zdiv_o(zdiv), .inval_o(inval)
   );

   function automatic logic [63:0] src_at(int i);
      case (i)
         0:  return 64'h0000_0000_0000_0000;
         1:  return 64'h8000_0000_0000_0000;
         2:  return 64'h3FF0_0000_0000_0000;
         3:  return 64'hBFF0_0000_0000_0000;
         4:  return 64'h7FF0_0000_0000_0000;
         5:  return 64'hFFF0_0000_0000_0000;
         6:  return 64'h7FF8_0000_0000_0123;
         7:  return 64'h7FF0_0000_0000_0456;
         8:  return 64'hFFF0_0000_0000_0001;
         9:  return 64'h0000_0000_0000_0ABC;
         10: return 64'h800F_0000_0000_0001;
         11: return 64'h4004_0000_0000_0000;
         12: return 64'hC008_0000_0000_0000;
         13: return 64'hFFF8_0000_0000_0007;
         14: return 64'h3FF0_0000_0000_0001;
         default: return 64'h0010_0000_0000_0000;
      endcase
   endfunction

   function automatic logic [63:0] work_of(logic [63:0] s, logic d);
      return (d && s[62:52] == 11'd0) ? 64'd0 : s;
   endfunction

   function automatic int class_of(logic [63:0] w);
      if (w[62:52] == 11'h7FF) begin
         if (w[51:0] != 0) return w[51] ? 0 : 1;
         return w[63] ? 4 : 5;
      end
      if (w[62:0] == 0) return 2;
      if (w == 64'h3FF0_0000_0000_0000) return 3;
      return w[63] ? 6 : 7;
   endfunction

   function automatic logic [63:0] resp_of(int code, logic [63:0] w, logic [63:0] p);
      case (code)
         0:  return p;
         1:  return w;
         2:  return w | 64'h0008_0000_0000_0000;
         3:  return 64'hFFF8_0000_0000_0000;
         4:  return 64'hFFF0_0000_0000_0000;
         5:  return 64'h7FF0_0000_0000_0000;
         6:  return w[63] ? 64'hFFF0_0000_0000_0000 : 64'h7FF0_0000_0000_0000;
         7:  return 64'h8000_0000_0000_0000;
         8:  return 64'h0;
         9:  return 64'hBFF0_0000_0000_0000;
         10: return 64'h3FF0_0000_0000_0000;
         11: return 64'h3FE0_0000_0000_0000;
         12: return 64'h4056_8000_0000_0000;
         13: return 64'h3FF9_21FB_5444_2D18;
         14: return 64'h7FEF_FFFF_FFFF_FFFF;
         default: return 64'hFFEF_FFFF_FFFF_FFFF;
      endcase
   endfunction

   task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive one vector, confirm the previous answer still holds (R11), then check the new one
   task automatic apply(logic [63:0] s, logic [31:0] t, logic [63:0] p, logic [7:0] m,
                        logic d, logic w, logic z, string req, bit chk_val, bit chk_flg);
      logic [63:0] wk, e_res;
      logic        e_zd, e_iv;
      int          c;
      @(negedge clk);
      cmp("R11", "held result", result, prev_res);
      cmp("R11", "held flags", {62'd0, zdiv, inval}, {62'd0, prev_zd, prev_iv});
      src = s; tbl = t; prior = p; rmask = m; daz = d; wen = w; zm = z;
      wk = work_of(s, d);
      c  = class_of(wk);
      if (w) e_res = resp_of(int'(t[c*4 +: 4]), wk, p);
      else   e_res = z ? 64'd0 : p;
      e_zd = w && ((c == 2 && m[0]) || (c == 3 && m[2]));
      e_iv = w && ((c == 2 && m[1]) || (c == 3 && m[3]) || (c == 1 && m[4]) ||
                   (c == 4 && m[5]) || (c == 6 && m[6]) || (c == 5 && m[7]));
      @(posedge clk);
      #1;
      if (chk_val) cmp(req, "result", result, e_res);
      if (chk_flg) cmp(req, "flags", {62'd0, zdiv, inval}, {62'd0, e_zd, e_iv});
      prev_res = e_res; prev_zd = e_zd; prev_iv = e_iv;
   endtask

   function automatic logic [31:0] next_rng(logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      cmp("R11", "reset result", result, 64'd0);
      cmp("R11", "reset flags", {62'd0, zdiv, inval}, 64'd0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      prev_res = 64'd0; prev_zd = 1'b0; prev_iv = 1'b0;

      // R1 / R2 / R3: distinct code per class exposes the class
      for (int i = 0; i < 16; i++)
         for (int d = 0; d < 2; d++)
            apply(src_at(i), 32'hFEDC_BA98, 64'h5555_AAAA_5555_AAAA, 8'h00, d[0], 1'b1, 1'b0,
                  (i == 9 || i == 10) ? (d != 0 ? "R2" : "R3") : "R1", 1'b1, 1'b1);

      // R5 / R6 / R7: every response code for every source
      for (int i = 0; i < 16; i++)
         for (int d = 0; d < 2; d++)
            for (int code = 0; code < 16; code++)
               apply(src_at(i), {8{code[3:0]}}, 64'h0123_4567_89AB_CDEF ^ 64'(i), 8'h00,
                     d[0], 1'b1, 1'b0, code < 4 ? "R5" : (code < 9 ? "R6" : "R7"), 1'b1, 1'b0);

      // R4: pseudo-random tables
      for (int i = 0; i < 16; i++)
         for (int k = 0; k < 32; k++) begin
            rng = next_rng(rng);
            apply(src_at(i), rng, {rng, ~rng}, 8'h00, k[0], 1'b1, 1'b0, "R4", 1'b1, 1'b0);
         end

      // R8 / R9: every report mask against every source
      for (int i = 0; i < 16; i++)
         for (int d = 0; d < 2; d++)
            for (int m = 0; m < 256; m++)
               apply(src_at(i), 32'h1111_1111, 64'd0, m[7:0], d[0], 1'b1, 1'b0,
                     (class_of(work_of(src_at(i), d[0])) inside {2, 3}) ? "R8" : "R9",
                     1'b0, 1'b1);

      // R10: disabled lane, merge and zeroing
      for (int i = 0; i < 16; i++)
         for (int z = 0; z < 2; z++) begin
            rng = next_rng(rng);
            apply(src_at(i), rng, 64'hDEAD_BEEF_0000_0000 | 64'(i), 8'hFF, 1'b1, 1'b0, z[0],
                  "R10", 1'b1, 1'b1);
         end

      @(negedge clk);
      cmp("R11", "final hold", result, prev_res);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule